// File: doc/BRIEF.md
# Time-Shared Dense Layer Engine

This block evaluates one fully connected neural-network layer per run on a row of N signed fixed-point multiply-accumulate lanes, and the same lanes serve every layer in turn. A six-phase controller captures a per-layer setting (how many output units are live, how many operand bits are meaningful, which activation to apply) and per-lane bias values. It then walks a step index across a shared input bus and a per-lane weight bus for N consecutive steps. Once the sums are complete, they are parked in a parallel-in serial-out register. A single activation unit drains that register one lane per cycle and presents each result on a write port.

A host holds the configuration and bias inputs steady from `start` until `done`. It answers `feed_idx` with the matching input and weight bytes in the same cycle, as a memory bank with a combinational read does. Changing layers means presenting a new setting and pulsing `start` again. No part of the datapath is reassigned between layers.

Top module: `nle_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `res_valid` and `feed_valid` are all low.
- R2: `start` is accepted only while idle. A pulse on `start` during a run has no effect: that run's results are unchanged and no further run follows it.
- R3: A run sampled on `start` spends one setup cycle with `feed_valid` low. `feed_valid` is then high for exactly N consecutive cycles, with `feed_idx` counting 0, 1, ..., N-1.
- R4: The sum for lane l equals its signed `cfg_bias` field (bits [l*BIAS_W +: BIAS_W]) plus the sum over steps k of the input byte times the lane's weight byte (bits [l*8 +: 8] of `w_bus`), taken while `feed_idx` = k. The sum is held in a signed ACC_W-bit accumulator that is reloaded at the start of every run.
- R5: `cfg_opw` gives the operand width b. Only the low b bits of each input and weight byte are used, read as a signed two's-complement value. A value of 0 or above 8 means 8.
- R6: When `cfg_act` = 0 (ReLU), the result is z = floor(sum / 2^SHIFT), clamped to 0..255.
- R7: When `cfg_act` = 1 (sigmoid), the result is 0 for z <= -64, 255 for z >= 64, and 128 + 2z otherwise. This is a linear ramp from -4.0 to +4.0 with z counted in sixteenths.
- R8: Results leave one per cycle on consecutive cycles, in lane order starting at lane 0, with `res_idx` naming the lane.
- R9: Only lanes below min(`cfg_units`, N) produce a result beat. A setting of 0 produces none.
- R10: `done` is high for exactly one cycle. That cycle also carries the last result beat when there is one, and the engine is idle on the next cycle.
- R11: Consecutive runs with different settings give results that depend only on their own setting, bias and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a layer run (honoured only when idle) |
| cfg_units | input | CNT_W | Number of live output lanes |
| cfg_opw | input | 4 | Meaningful operand bits |
| cfg_act | input | 1 | Activation select: 0 ReLU, 1 sigmoid |
| cfg_bias | input | N*BIAS_W | Signed bias for each lane |
| feed_valid | output | 1 | Step index is valid; operand buses are consumed |
| feed_idx | output | IDX_W | Current step index |
| x_bus | input | 8 | Shared input operand for the current step |
| w_bus | input | N*8 | Weight operand for each lane at the current step |
| res_valid | output | 1 | Result beat valid |
| res_idx | output | IDX_W | Lane of the current result |
| res_data | output | 8 | Activated result |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the engine with N = 4, ACC_W = 24, BIAS_W = 16 and SHIFT = 4. With only four lanes, a unit count above N fits in the 3-bit `cfg_units` field, so clamping, masking of upper lanes and the empty run can all be reached. With SHIFT = 4, a bias near ±1100 lands on both sigmoid knees, and a bias near ±32000 drives ReLU into both of its limits. Running a narrow operand width on full-range bytes shows whether the upper bits are really dropped. Back-to-back runs with a stray `start` pulse test whether any state carries over from one layer to the next.

// File: rtl/nle_pkg.sv
package nle_pkg;

  localparam int OPD_W     = 8;
  localparam int OUT_W     = 8;
  localparam int Z_FRAC    = 4;
  localparam int SIG_KNEE  = 4 << Z_FRAC;
  localparam int OUT_MAX   = (1 << OUT_W) - 1;
  localparam int SIG_MID   = 1 << (OUT_W - 1);
  localparam int SIG_SLOPE = SIG_MID / SIG_KNEE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_COMPUTE,
    ST_SERIAL,
    ST_ACT,
    ST_DONE
  } nle_state_e;

  typedef enum logic {
    ACT_RELU = 1'b0,
    ACT_SIGM = 1'b1
  } nle_act_e;

  function automatic logic signed [OPD_W-1:0] fit_operand(
    input logic [OPD_W-1:0] v,
    input logic [3:0]       wb
  );
    logic [3:0]       sh;
    logic [OPD_W-1:0] t;
    sh = (wb == 4'd0 || int'(wb) > OPD_W) ? 4'd0 : 4'(OPD_W - int'(wb));
    t  = v << sh;
    return $signed(t) >>> sh;
  endfunction

  function automatic logic [OUT_W-1:0] act_map(input int z, input nle_act_e sel);
    int y;
    if (sel == ACT_RELU) begin
      y = (z < 0) ? 0 : ((z > OUT_MAX) ? OUT_MAX : z);
    end else begin
      if (z <= -SIG_KNEE)     y = 0;
      else if (z >= SIG_KNEE) y = OUT_MAX;
      else                    y = SIG_MID + SIG_SLOPE * z;
    end
    return OUT_W'(y);
  endfunction

endpackage

// File: rtl/nle_mac_lane.sv
module nle_mac_lane
  import nle_pkg::*;
#(
  parameter int ACC_W  = 24,
  parameter int BIAS_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     preload,
  input  logic signed [BIAS_W-1:0] bias,
  input  logic                     mac_en,
  input  logic [3:0]               opw,
  input  logic [OPD_W-1:0]         x_raw,
  input  logic [OPD_W-1:0]         w_raw,
  output logic signed [ACC_W-1:0]  acc
);

  logic signed [OPD_W-1:0]   x_fit;
  logic signed [OPD_W-1:0]   w_fit;
  logic signed [2*OPD_W-1:0] prod;
  logic signed [ACC_W:0]     sum_ext;

  assign x_fit   = fit_operand(x_raw, opw);
  assign w_fit   = fit_operand(w_raw, opw);
  assign prod    = x_fit * w_fit;
  assign sum_ext = (ACC_W+1)'(acc) + (ACC_W+1)'(prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (preload) acc <= ACC_W'(bias);
    else if (mac_en)  acc <= sum_ext[ACC_W-1:0];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en |-> (sum_ext[ACC_W] == sum_ext[ACC_W-1])); // R4

endmodule

// File: rtl/nle_piso.sv
module nle_piso #(
  parameter int N = 8,
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [N*W-1:0] din,
  output logic [W-1:0] head
);

  logic [W-1:0] slot [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     slot[i] <= '0;
        else if (load)  slot[i] <= din[i*W +: W];
        else if (shift) slot[i] <= (i == N-1) ? '0 : slot[(i+1) % N];
      end
    end
  endgenerate

  assign head = slot[0];

endmodule

// File: rtl/nle_act.sv
module nle_act
  import nle_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int SHIFT = 4
) (
  input  logic signed [ACC_W-1:0] sum_in,
  input  nle_act_e                sel,
  output logic [OUT_W-1:0]        y
);

  logic signed [ACC_W-1:0] z_scaled;

  assign z_scaled = sum_in >>> SHIFT;
  assign y        = act_map(int'(z_scaled), sel);

endmodule

// File: rtl/nle_ctrl.sv
module nle_ctrl
  import nle_pkg::*;
#(
  parameter  int N     = 8,
  localparam int IDX_W = $clog2(N),
  localparam int CNT_W = $clog2(N+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] units,
  output nle_state_e       state,
  output logic             load_cfg,
  output logic             mac_en,
  output logic [IDX_W-1:0] step_idx,
  output logic             piso_load,
  output logic             piso_shift,
  output logic             beat_en,
  output logic [IDX_W-1:0] beat_idx,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt;
  logic             last_step;
  logic             last_beat;

  assign last_step = (cnt == CNT_W'(N-1));
  assign last_beat = (({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, units});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_LOAD;
        end
        ST_LOAD: begin
          cnt   <= '0;
          state <= ST_COMPUTE;
        end
        ST_COMPUTE: begin
          if (last_step) begin
            cnt   <= '0;
            state <= ST_SERIAL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SERIAL: begin
          cnt   <= '0;
          state <= ST_ACT;
        end
        ST_ACT: begin
          cnt <= cnt + 1'b1;
          if (last_beat) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign load_cfg   = (state == ST_LOAD);
  assign mac_en     = (state == ST_COMPUTE);
  assign step_idx   = cnt[IDX_W-1:0];
  assign piso_load  = (state == ST_SERIAL);
  assign piso_shift = (state == ST_ACT);
  assign beat_en    = (state == ST_ACT) && (cnt < units);
  assign beat_idx   = cnt[IDX_W-1:0];
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);

  AST_LOAD_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |-> ($past(state) == ST_IDLE && $past(start))); // R2

  AST_FEED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && $past(mac_en)) |-> (step_idx == $past(step_idx) + 1'b1)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && state == ST_IDLE)); // R10

endmodule

// File: rtl/nle_engine.sv
module nle_engine
  import nle_pkg::*;
#(
  parameter  int N      = 8,
  parameter  int ACC_W  = 24,
  parameter  int BIAS_W = 16,
  parameter  int SHIFT  = 4,
  localparam int IDX_W  = $clog2(N),
  localparam int CNT_W  = $clog2(N+1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CNT_W-1:0]    cfg_units,
  input  logic [3:0]          cfg_opw,
  input  logic                cfg_act,
  input  logic [N*BIAS_W-1:0] cfg_bias,
  output logic                feed_valid,
  output logic [IDX_W-1:0]    feed_idx,
  input  logic [OPD_W-1:0]    x_bus,
  input  logic [N*OPD_W-1:0]  w_bus,
  output logic                res_valid,
  output logic [IDX_W-1:0]    res_idx,
  output logic [OUT_W-1:0]    res_data,
  output logic                busy,
  output logic                done
);

  nle_state_e       state;
  logic             load_cfg;
  logic             mac_en;
  logic             piso_load;
  logic             piso_shift;
  logic             beat_en;
  logic [IDX_W-1:0] beat_idx;

  logic [CNT_W-1:0] units_q;
  logic [3:0]       opw_q;
  nle_act_e         act_q;

  logic [N*ACC_W-1:0] acc_flat;
  logic [ACC_W-1:0]   piso_head;
  logic [OUT_W-1:0]   act_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      units_q <= '0;
      opw_q   <= '0;
      act_q   <= ACT_RELU;
    end else if (load_cfg) begin
      units_q <= (cfg_units > CNT_W'(N)) ? CNT_W'(N) : cfg_units;
      opw_q   <= cfg_opw;
      act_q   <= nle_act_e'(cfg_act);
    end
  end

  nle_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .units      (units_q),
    .state      (state),
    .load_cfg   (load_cfg),
    .mac_en     (mac_en),
    .step_idx   (feed_idx),
    .piso_load  (piso_load),
    .piso_shift (piso_shift),
    .beat_en    (beat_en),
    .beat_idx   (beat_idx),
    .busy       (busy),
    .done       (done)
  );

  assign feed_valid = mac_en;

  generate
    for (genvar l = 0; l < N; l++) begin : g_lane
      logic signed [ACC_W-1:0] lane_acc;
      nle_mac_lane #(.ACC_W(ACC_W), .BIAS_W(BIAS_W)) u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .preload (load_cfg),
        .bias    ($signed(cfg_bias[l*BIAS_W +: BIAS_W])),
        .mac_en  (mac_en),
        .opw     (opw_q),
        .x_raw   (x_bus),
        .w_raw   (w_bus[l*OPD_W +: OPD_W]),
        .acc     (lane_acc)
      );
      assign acc_flat[l*ACC_W +: ACC_W] = lane_acc;
    end
  endgenerate

  nle_piso #(.N(N), .W(ACC_W)) u_piso (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (piso_load),
    .shift (piso_shift),
    .din   (acc_flat),
    .head  (piso_head)
  );

  nle_act #(.ACC_W(ACC_W), .SHIFT(SHIFT)) u_act (
    .sum_in ($signed(piso_head)),
    .sel    (act_q),
    .y      (act_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_idx   <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= beat_en;
      if (beat_en) begin
        res_idx  <= beat_idx;
        res_data <= act_y;
      end
    end
  end

  AST_BEAT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ({1'b0, res_idx} < (IDX_W+1)'(units_q))); // R9

  AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(res_valid)) |-> (res_idx == $past(res_idx) + 1'b1)); // R8

  AST_DONE_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !load_cfg); // R2

endmodule

// File: tb/nle_engine_test.sv
module nle_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int N      = 4;
  localparam int ACC_W  = 24;
  localparam int BIAS_W = 16;
  localparam int SHIFT  = 4;
  localparam int IDX_W  = $clog2(N);
  localparam int CNT_W  = $clog2(N+1);

  typedef struct {
    int    idx;
    int    data;
    string tag;
  } beat_t;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [CNT_W-1:0]    cfg_units = '0;
  logic [3:0]          cfg_opw = '0;
  logic                cfg_act = 1'b0;
  logic [N*BIAS_W-1:0] cfg_bias;
  logic                feed_valid;
  logic [IDX_W-1:0]    feed_idx;
  logic [7:0]          x_bus;
  logic [N*8-1:0]      w_bus;
  logic                res_valid;
  logic [IDX_W-1:0]    res_idx;
  logic [7:0]          res_data;
  logic                busy;
  logic                done;

  int xv [N];
  int wv [N][N];
  int bv [N];

  beat_t exp_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign x_bus = 8'(xv[feed_idx]);
  generate
    for (genvar l = 0; l < N; l++) begin : g_bank
      assign w_bus[l*8 +: 8]           = 8'(wv[l][feed_idx]);
      assign cfg_bias[l*BIAS_W +: BIAS_W] = BIAS_W'(bv[l]);
    end
  endgenerate

  nle_engine #(.N(N), .ACC_W(ACC_W), .BIAS_W(BIAS_W), .SHIFT(SHIFT)) uut (
    .clk, .rst_n, .start, .cfg_units, .cfg_opw, .cfg_act, .cfg_bias,
    .feed_valid, .feed_idx, .x_bus, .w_bus,
    .res_valid, .res_idx, .res_data, .busy, .done
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int actual, input int expected);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
    end
  endtask

  function automatic int narrow(input int v, input int wb);
    int b, m;
    b = (wb == 0 || wb > 8) ? 8 : wb;
    m = v & ((1 << b) - 1);
    if (m >= (1 << (b - 1))) m = m - (1 << b);
    return m;
  endfunction

  function automatic int floor_div(input int a, input int d);
    if (a >= 0) return a / d;
    return -((-a + d - 1) / d);
  endfunction

  function automatic int model_out(input int sum, input int act);
    int  z;
    real r;
    z = floor_div(sum, 1 << SHIFT);
    if (act == 0) begin
      if (z < 0)   return 0;
      if (z > 255) return 255;
      return z;
    end
    r = 256.0 * (0.5 + (real'(z) / 16.0) / 8.0);
    if (r < 0.0)   return 0;
    if (r > 255.0) return 255;
    return $rtoi(r);
  endfunction

  task automatic fill(input int seed, input bit wide);
    for (int k = 0; k < N; k++) begin
      xv[k] = wide ? (((k * 53 + seed * 17) % 256) - 128)
                   : (((k * 7 + seed * 13) % 41) - 20);
      for (int l = 0; l < N; l++)
        wv[l][k] = wide ? (((l * 71 + k * 29 + seed * 5) % 256) - 128)
                        : (((l * 11 + k * 5 + seed * 3) % 41) - 20);
    end
    for (int l = 0; l < N; l++) bv[l] = ((l * 97 + seed * 29) % 401) - 200;
  endtask

  // Scoreboard driver: pushes expected beats, runs one layer, checks control timing.
  task automatic run_layer(input int units, input int opw, input int act,
                           input string tag, input bit poke_start);
    int live;
    live = (units > N) ? N : units;
    for (int l = 0; l < live; l++) begin
      int    sum;
      beat_t b;
      sum = bv[l];
      for (int k = 0; k < N; k++) sum += narrow(xv[k], opw) * narrow(wv[l][k], opw);
      b.idx  = l;
      b.data = model_out(sum, act);
      b.tag  = tag;
      exp_q.push_back(b);
    end
    @(negedge clk);
    cfg_units = CNT_W'(units);
    cfg_opw   = 4'(opw);
    cfg_act   = act[0];
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(feed_valid == 1'b0 && busy == 1'b1, "R3", "setup cycle feed_valid",
          int'(feed_valid), 0);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      check(feed_valid == 1'b1 && int'(feed_idx) == k, "R3", "feed step index",
            int'(feed_idx), k);
      start = (poke_start && k == 1);
    end
    start = 1'b0;
    @(negedge clk);
    check(feed_valid == 1'b0, "R3", "feed ends after N steps", int'(feed_valid), 0);
    begin
      int waited = 0;
      while (!done && waited < 200) begin
        @(negedge clk);
        waited++;
      end
      check(done == 1'b1, "R10", "done seen", int'(done), 1);
    end
    check(res_valid == (live > 0), "R10", "last beat with done", int'(res_valid),
          int'(live > 0));
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10", "done one cycle then idle",
          int'(done) + int'(busy), 0);
    check(exp_q.size() == 0, "R9", "all expected beats produced", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R2", "no run from stray start", int'(busy), 0);
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected beat for lane", int'(res_idx), -1);
        end else begin
          beat_t b;
          b = exp_q.pop_front();
          check(int'(res_idx) == b.idx, "R8", "beat lane order", int'(res_idx), b.idx);
          check(int'(res_data) == b.data, b.tag, "result value", int'(res_data), b.data);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    fill(0, 1'b0);
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && res_valid == 0 && feed_valid == 0, "R1",
          "reset state", int'(busy) + int'(done) + int'(res_valid) + int'(feed_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    fill(1, 1'b0);  run_layer(4, 8, 0, "R4_R6", 1'b0);   // full ReLU layer
    fill(2, 1'b0);  run_layer(2, 8, 1, "R7_R9", 1'b0);   // masked sigmoid layer
    fill(3, 1'b0);  run_layer(0, 8, 0, "R9", 1'b0);      // no live lanes
    fill(4, 1'b0);  run_layer(7, 8, 1, "R9_R7", 1'b0);   // count above N clamps
    fill(5, 1'b1);  run_layer(4, 4, 0, "R5", 1'b0);      // narrow operands
    fill(6, 1'b1);  run_layer(4, 0, 1, "R5_R7", 1'b0);   // width 0 means full 8

    for (int k = 0; k < N; k++) begin
      xv[k] = 0;
      for (int l = 0; l < N; l++) wv[l][k] = 0;
    end
    bv[0] = 32000; bv[1] = -32000; bv[2] = 1100; bv[3] = -1100;
    run_layer(4, 8, 0, "R6", 1'b0);                       // ReLU clamps
    run_layer(4, 8, 1, "R7", 1'b0);                       // sigmoid knees
    bv[0] = -1; bv[1] = 1023; bv[2] = -1024; bv[3] = 16;
    run_layer(4, 8, 1, "R7", 1'b0);                       // ramp and knee edges

    fill(7, 1'b0);  run_layer(3, 8, 0, "R11_R2", 1'b1);  // stray start mid-run
    fill(8, 1'b1);  run_layer(4, 6, 1, "R11", 1'b0);     // new setting follows

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule